// File: doc/BRIEF.md
# Power-on Strap Capture and Configuration Port

This block handles a bank of seven configuration strap pads. While reset is asserted, the chip leaves these pads undriven so that pull resistors set their levels. On every clock of reset the block samples the pads. When reset is released it freezes the sampled word, and that word stays fixed until the next reset. The captured word is then put to two uses.

First, software can read it as a read-only register. Access goes through an index/data pair on a small I/O bus. Second, some of its bits drive hardware directly:

- a clock test routing mode,
- forcing of two status output enables to off,
- the reset default of a clock-source selection register that software can overwrite.

The I/O bus is single-cycle, and its reads are combinational. There is no back-pressure: every access completes in the cycle it is presented.

Top module: `strap_cfg_top`

## Requirements
- R1: `strap_in[i]` is reported as configuration bit i+1. The word held after reset is the pad value at the last rising clock edge with `rst` high. Pad changes after reset have no effect until the next reset.
- R2: While `rst` is high, every bit of `strap_oe` is 0 regardless of `strap_oe_req`. Outside reset, `strap_oe` equals `strap_oe_req`.
- R3: A write to address 0x3D6 loads the 8-bit index. A read of 0x3D6 returns the index. Reset clears the index to 0x00.
- R4: A read of 0x3D7 with index 0x70 returns the configuration word. Bits 7..1 hold the captured straps, and bit 0 always reads 1.
- R5: A write to 0x3D7 while the index is 0x70 leaves the configuration word unchanged.
- R6: A read of 0x3D7 with any index other than 0x70 or 0xCF returns 0x00. A read of any other address returns 0x00. `io_rdata` is 0x00 whenever `io_rd` is low.
- R7: When configuration bit 7 is 0 (test mode), `rom_cs_out` carries `mclk_int` and `vid_clk_out` carries `vclk_int`. When bit 7 is 1, these outputs carry `rom_cs_func` and `vid_clk_func`.
- R8: When configuration bit 6 is 0, `stat_oe` is 0. When bit 6 is 1, `stat_oe` equals `stat_oe_req`.
- R9: The clock-select register sits at index 0xCF. Bit 2 selects the memory clock source and bit 1 selects the display clock source, with 1 meaning internal. Both bits reset to configuration bit 4. Both are writable through 0x3D7, and the other bits of this register read 0.
- R10: `mclk_out` is `mclk_int` when select bit 2 is 1 and `mclk_ext` otherwise. `dclk_out` is `dclk_int` when select bit 1 is 1 and `dclk_ext` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also the strap capture window |
| strap_in | input | 7 | Strap pad levels, bit i maps to configuration bit i+1 |
| strap_oe_req | input | 7 | Function-logic output-enable requests for the strap pads |
| strap_oe | output | 7 | Gated strap pad output enables |
| stat_oe_req | input | 2 | Output-enable requests for the two status pads |
| stat_oe | output | 2 | Status pad output enables after strap forcing |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data |
| mclk_int | input | 1 | Internal memory clock candidate |
| mclk_ext | input | 1 | External memory clock candidate |
| dclk_int | input | 1 | Internal display clock candidate |
| dclk_ext | input | 1 | External display clock candidate |
| vclk_int | input | 1 | Internal video clock synthesizer output |
| rom_cs_func | input | 1 | Normal ROM chip-select value |
| vid_clk_func | input | 1 | Normal video port clock value |
| mclk_out | output | 1 | Selected memory clock |
| dclk_out | output | 1 | Selected display clock |
| rom_cs_out | output | 1 | ROM chip-select pad value |
| vid_clk_out | output | 1 | Video port clock pad value |

## Verification
The bench sweeps all 128 strap words. For each word it changes the pads during reset and again after release. A design that captured one cycle early, or kept tracking the pads after reset, would report the wrong word. It checks that writes to the read-only index cannot disturb the word. It checks that the clock-select defaults come from the strap in the same clock edge as the capture. A default taken one cycle late would hold a stale bit. A further sweep over all 256 index values checks that only the two implemented indices return data. It also checks that test routing and status-enable forcing track the right strap bit. A design with a swapped bit position would fail half of the sweep.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int unsigned CFG_W   = 8;
  localparam int unsigned STRAP_W = CFG_W - 1;

  // configuration word bit positions that hardware decodes
  localparam int unsigned BIT_TEST_N = 7;
  localparam int unsigned BIT_STAT_EN = 6;
  localparam int unsigned BIT_CLK_INT = 4;

  // clock-select register bit positions
  localparam int unsigned SEL_M_BIT = 2;
  localparam int unsigned SEL_D_BIT = 1;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_INDEX,
    RD_DATA
  } rd_kind_e;

  // latch vector position of a configuration bit
  function automatic int unsigned lat_pos(input int unsigned cfg_bit);
    return cfg_bit - 1;
  endfunction
endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int unsigned W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] strap_in,
  output logic [W-1:0] lat_q
);
  // sample on every edge of the reset window, hold otherwise
  always_ff @(posedge clk) begin
    if (rst) lat_q <= strap_in;
  end
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import strap_cfg_pkg::*;
#(
  parameter int unsigned         ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]   IDX_PORT  = 16'h03D6,
  parameter logic [ADDR_W-1:0]   DAT_PORT  = 16'h03D7,
  parameter logic [CFG_W-1:0]    STRAP_IDX = 8'h70,
  parameter logic [CFG_W-1:0]    CSEL_IDX  = 8'hCF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [CFG_W-1:0]  io_wdata,
  output logic [CFG_W-1:0]  io_rdata,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              csel_dflt,
  output logic [CFG_W-1:0]  idx_q,
  output logic              msel,
  output logic              dsel
);
  rd_kind_e rd_kind;
  logic     hit_idx, hit_dat, wr_csel;

  assign hit_idx = (io_addr == IDX_PORT);
  assign hit_dat = (io_addr == DAT_PORT);
  assign wr_csel = io_wr && hit_dat && (idx_q == CSEL_IDX);

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else if (io_wr && hit_idx) idx_q <= io_wdata;
  end

  // default follows the strap pad on the same edges as the capture latch
  always_ff @(posedge clk) begin
    if (rst) begin
      msel <= csel_dflt;
      dsel <= csel_dflt;
    end else if (wr_csel) begin
      msel <= io_wdata[SEL_M_BIT];
      dsel <= io_wdata[SEL_D_BIT];
    end
  end

  always_comb begin
    if (!io_rd)       rd_kind = RD_NONE;
    else if (hit_idx) rd_kind = RD_INDEX;
    else if (hit_dat) rd_kind = RD_DATA;
    else              rd_kind = RD_NONE;
  end

  always_comb begin
    io_rdata = '0;
    case (rd_kind)
      RD_INDEX: io_rdata = idx_q;
      RD_DATA: begin
        if (idx_q == STRAP_IDX) io_rdata = cfg_word;
        else if (idx_q == CSEL_IDX) begin
          io_rdata[SEL_M_BIT] = msel;
          io_rdata[SEL_D_BIT] = dsel;
        end
      end
      default: io_rdata = '0;
    endcase
  end
endmodule

// File: rtl/clk_route.sv
module clk_route (
  input  logic test_n,
  input  logic msel,
  input  logic dsel,
  input  logic mclk_int,
  input  logic mclk_ext,
  input  logic dclk_int,
  input  logic dclk_ext,
  input  logic vclk_int,
  input  logic rom_cs_func,
  input  logic vid_clk_func,
  output logic mclk_out,
  output logic dclk_out,
  output logic rom_cs_out,
  output logic vid_clk_out
);
  localparam int unsigned NMUX = 2;
  logic [NMUX-1:0] sel_v, int_v, ext_v, out_v;

  assign sel_v = {dsel, msel};
  assign int_v = {dclk_int, mclk_int};
  assign ext_v = {dclk_ext, mclk_ext};

  for (genvar g = 0; g < NMUX; g++) begin : g_src
    assign out_v[g] = sel_v[g] ? int_v[g] : ext_v[g];
  end

  assign mclk_out = out_v[0];
  assign dclk_out = out_v[1];

  // active-low test strap puts synthesizer outputs on pads
  assign rom_cs_out  = test_n ? rom_cs_func  : mclk_int;
  assign vid_clk_out = test_n ? vid_clk_func : vclk_int;
endmodule

// File: rtl/pad_ctl.sv
module pad_ctl #(
  parameter int unsigned N_PAD  = 7,
  parameter int unsigned N_STAT = 2
) (
  input  logic              rst,
  input  logic [N_PAD-1:0]  strap_oe_req,
  output logic [N_PAD-1:0]  strap_oe,
  input  logic              stat_en,
  input  logic [N_STAT-1:0] stat_oe_req,
  output logic [N_STAT-1:0] stat_oe
);
  for (genvar p = 0; p < N_PAD; p++) begin : g_strap
    assign strap_oe[p] = strap_oe_req[p] & ~rst;
  end
  for (genvar s = 0; s < N_STAT; s++) begin : g_stat
    assign stat_oe[s] = stat_oe_req[s] & stat_en;
  end
endmodule

// File: rtl/strap_cfg_top.sv
module strap_cfg_top
  import strap_cfg_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h03D6,
  parameter logic [ADDR_W-1:0] DAT_PORT  = 16'h03D7,
  parameter logic [7:0]        STRAP_IDX = 8'h70,
  parameter logic [7:0]        CSEL_IDX  = 8'hCF,
  parameter int unsigned       N_STAT    = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [STRAP_W-1:0]   strap_in,
  input  logic [STRAP_W-1:0]   strap_oe_req,
  output logic [STRAP_W-1:0]   strap_oe,
  input  logic [N_STAT-1:0]    stat_oe_req,
  output logic [N_STAT-1:0]    stat_oe,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic                 io_wr,
  input  logic                 io_rd,
  input  logic [CFG_W-1:0]     io_wdata,
  output logic [CFG_W-1:0]     io_rdata,
  input  logic                 mclk_int,
  input  logic                 mclk_ext,
  input  logic                 dclk_int,
  input  logic                 dclk_ext,
  input  logic                 vclk_int,
  input  logic                 rom_cs_func,
  input  logic                 vid_clk_func,
  output logic                 mclk_out,
  output logic                 dclk_out,
  output logic                 rom_cs_out,
  output logic                 vid_clk_out
);
  localparam int unsigned P_TEST = lat_pos(BIT_TEST_N);
  localparam int unsigned P_STAT = lat_pos(BIT_STAT_EN);
  localparam int unsigned P_CLK  = lat_pos(BIT_CLK_INT);

  logic [STRAP_W-1:0] lat_q;
  logic [CFG_W-1:0]   cfg_word;
  logic [CFG_W-1:0]   idx_q;
  logic               msel, dsel;

  strap_latch #(.W(STRAP_W)) u_latch (
    .clk(clk), .rst(rst), .strap_in(strap_in), .lat_q(lat_q)
  );

  assign cfg_word = {lat_q, 1'b1};

  cfg_regs #(
    .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT),
    .STRAP_IDX(STRAP_IDX), .CSEL_IDX(CSEL_IDX)
  ) u_regs (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_word(cfg_word),
    .csel_dflt(strap_in[P_CLK]), .idx_q(idx_q), .msel(msel), .dsel(dsel)
  );

  clk_route u_clk (
    .test_n(lat_q[P_TEST]), .msel(msel), .dsel(dsel),
    .mclk_int(mclk_int), .mclk_ext(mclk_ext),
    .dclk_int(dclk_int), .dclk_ext(dclk_ext), .vclk_int(vclk_int),
    .rom_cs_func(rom_cs_func), .vid_clk_func(vid_clk_func),
    .mclk_out(mclk_out), .dclk_out(dclk_out),
    .rom_cs_out(rom_cs_out), .vid_clk_out(vid_clk_out)
  );

  pad_ctl #(.N_PAD(STRAP_W), .N_STAT(N_STAT)) u_pads (
    .rst(rst), .strap_oe_req(strap_oe_req), .strap_oe(strap_oe),
    .stat_en(lat_q[P_STAT]), .stat_oe_req(stat_oe_req), .stat_oe(stat_oe)
  );
endmodule

// File: rtl/strap_cfg_chk.sv
module strap_cfg_chk #(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] IDX_PORT  = 16'h03D6,
  parameter logic [ADDR_W-1:0] DAT_PORT  = 16'h03D7,
  parameter logic [7:0]        STRAP_IDX = 8'h70,
  parameter logic [7:0]        CSEL_IDX  = 8'hCF,
  parameter int unsigned       N_STAT    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [6:0]        strap_oe,
  input logic [N_STAT-1:0] stat_oe,
  input logic [N_STAT-1:0] stat_oe_req,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic [7:0]        io_rdata,
  input logic [7:0]        idx_q,
  input logic [6:0]        lat_q
);
  always @(posedge clk) begin
    if (rst === 1'b1) AST_OE_QUIET_IN_RESET: assert (strap_oe == '0); // R2
  end

  AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(lat_q)); // R1

  AST_INDEX_CLEARED: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !$past(io_wr)) |-> (idx_q == 8'h00)); // R3

  AST_CFG_BIT0_SET: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == DAT_PORT && idx_q == STRAP_IDX) |-> io_rdata[0]); // R4

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (io_rd && io_addr == DAT_PORT && idx_q != STRAP_IDX && idx_q != CSEL_IDX)
      |-> (io_rdata == 8'h00)); // R6

  AST_NO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !io_rd |-> (io_rdata == 8'h00)); // R6

  AST_STAT_FORCED: assert property (@(posedge clk) disable iff (rst)
    !lat_q[5] |-> (stat_oe == '0)); // R8

  AST_STAT_PASS: assert property (@(posedge clk) disable iff (rst)
    lat_q[5] |-> (stat_oe == stat_oe_req)); // R8
endmodule

bind strap_cfg_top strap_cfg_chk #(
  .ADDR_W(ADDR_W), .IDX_PORT(IDX_PORT), .DAT_PORT(DAT_PORT),
  .STRAP_IDX(STRAP_IDX), .CSEL_IDX(CSEL_IDX), .N_STAT(N_STAT)
) u_chk (
  .clk(clk), .rst(rst), .strap_oe(strap_oe), .stat_oe(stat_oe),
  .stat_oe_req(stat_oe_req), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
  .io_rdata(io_rdata), .idx_q(idx_q), .lat_q(lat_q)
);

// File: tb/tb_strap_cfg_top.sv
module tb_strap_cfg_top;
  localparam int CLK_P = 10;
  localparam logic [15:0] IDXA = 16'h03D6;
  localparam logic [15:0] DATA = 16'h03D7;

  logic clk = 0, rst = 1;
  logic [6:0] strap_in = '0, strap_oe_req = '0, strap_oe;
  logic [1:0] stat_oe_req = '0, stat_oe;
  logic [15:0] io_addr = '0;
  logic io_wr = 0, io_rd = 0;
  logic [7:0] io_wdata = '0, io_rdata;
  logic mclk_int = 0, mclk_ext = 0, dclk_int = 0, dclk_ext = 0, vclk_int = 0;
  logic rom_cs_func = 0, vid_clk_func = 0;
  logic mclk_out, dclk_out, rom_cs_out, vid_clk_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  strap_cfg_top dut (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1; #1 d = io_rdata; io_rd = 0;
  endtask

  task automatic reset_with(input logic [6:0] v);
    @(negedge clk); rst = 1; strap_in = ~v; strap_oe_req = '1;
    #1 chk({1'b0, strap_oe}, 8'h00, "R2 oe in reset");
    repeat (2) @(negedge clk);
    strap_in = v;
    @(negedge clk); // capture edge with v
    rst = 0; strap_in = ~v;
  endtask

  initial begin
    logic [7:0] d;
    for (int v = 0; v < 128; v++) begin
      logic [6:0] s;
      s = v[6:0];
      reset_with(s);
      rd(IDXA, d); chk(d, 8'h00, "R3 index reset");
      #1 chk({1'b0, strap_oe}, 8'h7F, "R2 oe pass");
      wr(IDXA, 8'h70);
      rd(DATA, d); chk(d, {s, 1'b1}, "R1/R4 cfg word");
      wr(DATA, ~{s, 1'b1});
      rd(DATA, d); chk(d, {s, 1'b1}, "R5 write ignored");
      stat_oe_req = 2'b11; #1
      chk({6'b0, stat_oe}, s[5] ? 8'h03 : 8'h00, "R8 stat oe");
      for (int p = 0; p < 4; p++) begin
        mclk_int = p[0]; vclk_int = p[1]; rom_cs_func = ~p[0]; vid_clk_func = ~p[1];
        #1 chk({6'b0, rom_cs_out, vid_clk_out},
               s[6] ? {6'b0, ~p[0], ~p[1]} : {6'b0, p[0], p[1]}, "R7 test route");
      end
      wr(IDXA, 8'hCF);
      rd(DATA, d); chk(d, {5'b0, s[3], s[3], 1'b0}, "R9 csel default");
      mclk_int = 1; mclk_ext = 0; dclk_int = 0; dclk_ext = 1; #1
      chk({6'b0, mclk_out, dclk_out}, {6'b0, s[3], ~s[3]}, "R10 clock mux");
      wr(DATA, 8'hFB); // bit2=0, bit1=1
      rd(DATA, d); chk(d, 8'h02, "R9 csel write");
      #1 chk({6'b0, mclk_out, dclk_out}, 8'h00, "R10 clock mux after write");
      wr(DATA, 8'h04);
      #1 chk({6'b0, mclk_out, dclk_out}, 8'h03, "R10 clock mux swapped");
    end
    for (int i = 0; i < 256; i++) begin
      wr(IDXA, i[7:0]);
      rd(IDXA, d); chk(d, i[7:0], "R3 index readback");
      rd(DATA, d);
      if (i[7:0] != 8'h70 && i[7:0] != 8'hCF) chk(d, 8'h00, "R6 unimplemented index");
    end
    rd(16'h03D5, d); chk(d, 8'h00, "R6 other address");
    @(negedge clk); io_addr = DATA; #1 chk(io_rdata, 8'h00, "R6 no read strobe");
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule